// File: doc/BRIEF.md
# Latched Two-Digit Hex Display Driver

This block stores one byte and shows it as two hexadecimal characters on a seven-segment display whose segment lines are shared by both digits. A write-enable strobe loads the byte. At any clock edge where the strobe is low, the stored value stays unchanged and keeps being displayed.

The block alternates between the two digits at a fixed refresh rate. One output line tells the display which digit the segment bus is driving. The segment bus always carries the glyph of the nibble that belongs to the digit currently selected. A synchronous reset clears the stored byte, which makes the display read "00", and restarts the refresh timing.

Top module: `hex_pair_display`

## Requirements
- R1: On a rising clock edge where `writeEn` is 1, the byte on `dataIn` becomes the stored value.
- R2: On an edge where `writeEn` is 0, `dataIn` has no effect and both digits keep showing the previously stored value.
- R3: When `digitSel` is 0, the segment bus shows stored bits [7:4] (left digit). When `digitSel` is 1, it shows stored bits [3:0] (right digit).
- R4: Segments are active-high and `segOut[0]` through `segOut[6]` drive segments a through g. The glyph codes for nibbles 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71, given in hex with bit 0 being segment a.
- R5: `digitSel` is 0 for the first 2^REFRESH_BITS clocks after reset. After that it inverts every 2^REFRESH_BITS clocks.
- R6: While `rst` is high at an edge, the stored byte becomes 0x00 and the refresh timing restarts. After that edge, `digitSel` is 0 and the segment bus shows glyph 0.
- R7: A `writeEn` pulse lasting exactly one clock captures the `dataIn` value present at that edge. Later changes on `dataIn` have no effect.
- R8: The segment bus changes in the same cycle as `digitSel` or the stored value, with no extra register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Byte to capture |
| writeEn | input | 1 | Capture strobe, active high |
| segOut | output | 7 | Segment lines a..g on bits 0..6, active high |
| digitSel | output | 1 | 0 selects the left digit, 1 selects the right digit |

## Verification
The hardest case is showing that an ignored write really was ignored. Nothing at the ports shows whether the stored byte moved. The only evidence is both digit glyphs staying the same across a full refresh period after `dataIn` changes with the strobe low.

The scoreboard handles this by pushing the previously captured byte as the expected item and then checking both digit positions across two full refresh halves. Single-cycle strobes are followed at once by the inverted byte on `dataIn`, so a capture taken one edge late would show up in the glyphs.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;

  localparam int SEG_W    = 7;
  localparam int NIBBLE_W = 4;

  typedef struct packed {
    logic captureEn;
    logic showRight;
  } dispCtrl_t;

  function automatic logic [SEG_W-1:0] nibbleGlyph(input logic [NIBBLE_W-1:0] nib);
    logic [SEG_W-1:0] g;
    case (nib)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hexdisp_ctrl.sv
module hexdisp_ctrl
  import hexdisp_pkg::*;
#(
  parameter int REFRESH_BITS = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      writeEn,
  output dispCtrl_t ctrl
);

  localparam int CNT_W = REFRESH_BITS + 1;

  logic [CNT_W-1:0] refreshCnt;

  always_ff @(posedge clk) begin
    if (rst) refreshCnt <= '0;
    else     refreshCnt <= refreshCnt + 1'b1;
  end

  always_comb begin
    ctrl.captureEn = writeEn;
    ctrl.showRight = refreshCnt[CNT_W-1];
  end

endmodule

// File: rtl/hexdisp_datapath.sv
module hexdisp_datapath
  import hexdisp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dispCtrl_t         ctrl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] heldByte,
  output logic [SEG_W-1:0]  segOut
);

  localparam int DIGITS = DATA_W / NIBBLE_W;

  logic [SEG_W-1:0] digitGlyph [DIGITS];

  always_ff @(posedge clk) begin
    if (rst)                 heldByte <= '0;
    else if (ctrl.captureEn) heldByte <= dataIn;
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    always_comb digitGlyph[d] = nibbleGlyph(heldByte[d*NIBBLE_W +: NIBBLE_W]);
  end

  // digit 0 is the low nibble (right); the top digit is the left one
  always_comb segOut = ctrl.showRight ? digitGlyph[0] : digitGlyph[DIGITS-1];

endmodule

// File: rtl/hex_pair_display.sv
module hex_pair_display
  import hexdisp_pkg::*;
#(
  parameter int REFRESH_BITS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] dataIn,
  input  logic       writeEn,
  output logic [6:0] segOut,
  output logic       digitSel
);

  dispCtrl_t  ctrl;
  logic [7:0] heldByte;

  hexdisp_ctrl #(.REFRESH_BITS(REFRESH_BITS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .writeEn (writeEn),
    .ctrl    (ctrl)
  );

  hexdisp_datapath #(.DATA_W(8)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .dataIn   (dataIn),
    .heldByte (heldByte),
    .segOut   (segOut)
  );

  assign digitSel = ctrl.showRight;

endmodule

// File: rtl/hex_pair_display_checker.sv
module hex_pair_display_checker #(
  parameter int REFRESH_BITS = 10
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] dataIn,
  input logic       writeEn,
  input logic [6:0] segOut,
  input logic       digitSel,
  input logic [7:0] heldByte
);

  logic [REFRESH_BITS-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (rst) phaseCnt <= '0;
    else     phaseCnt <= phaseCnt + 1'b1;
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
    writeEn |=> heldByte == $past(dataIn));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!writeEn && !rst) |=> $stable(heldByte));

  assert_select_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (phaseCnt != '1) |=> $stable(digitSel));

  assert_select_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (phaseCnt == '1) |=> digitSel != $past(digitSel));

  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (heldByte == 8'h00 && !digitSel && segOut == 7'h3F));

  assert_seg_steady_R8: assert property (@(posedge clk) disable iff (rst)
    ($stable(heldByte) && $stable(digitSel)) |-> $stable(segOut));

endmodule

bind hex_pair_display hex_pair_display_checker #(.REFRESH_BITS(REFRESH_BITS)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .dataIn   (dataIn),
  .writeEn  (writeEn),
  .segOut   (segOut),
  .digitSel (digitSel),
  .heldByte (heldByte)
);

// File: tb/hex_pair_display_bench.sv
module hex_pair_display_bench;

  localparam int RB     = 3;
  localparam int HALF   = 1 << RB;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic       writeEn = 1'b0;
  logic [6:0] segOut;
  logic       digitSel;

  int checks = 0;
  int fails  = 0;
  bit monBusy = 1'b0;
  bit done = 1'b0;
  logic [7:0] pending [$];

  always #5 clk = ~clk;

  hex_pair_display #(.REFRESH_BITS(RB)) u_hex_pair_display (
    .clk(clk), .rst(rst), .dataIn(dataIn), .writeEn(writeEn),
    .segOut(segOut), .digitSel(digitSel)
  );

  function automatic logic [6:0] refGlyph(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: each expected byte is checked on both digits over a full refresh cycle
  initial begin
    forever begin
      logic [7:0] exp;
      wait (pending.size() > 0);
      monBusy = 1'b1;
      exp = pending.pop_front();
      for (int i = 0; i < 2 * HALF; i++) begin
        @(negedge clk);
        if (digitSel)
          check(segOut == refGlyph(exp[3:0]), "R3/R4 right digit", segOut, refGlyph(exp[3:0]));
        else
          check(segOut == refGlyph(exp[7:4]), "R3/R4 left digit", segOut, refGlyph(exp[7:4]));
      end
      monBusy = 1'b0;
    end
  end

  task automatic waitMonitor();
    wait (pending.size() == 0 && !monBusy);
  endtask

  // R1/R7: single-cycle strobe, bus scrambled right after the capturing edge
  task automatic writeByte(input logic [7:0] v);
    @(negedge clk);
    dataIn  = v;
    writeEn = 1'b1;
    @(negedge clk);
    writeEn = 1'b0;
    dataIn  = ~v;
    pending.push_back(v);
    waitMonitor();
  endtask

  // R2: bus changes with the strobe low; expect the old value
  task automatic idleBus(input logic [7:0] junk, input logic [7:0] held);
    @(negedge clk);
    dataIn = junk;
    @(negedge clk);
    pending.push_back(held);
    waitMonitor();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R6 and R5: reset state and refresh timing
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4 * HALF; i++) begin
      check(digitSel == ((i / HALF) % 2), "R5 select timing", digitSel, (i / HALF) % 2);
      if (i == 0) check(segOut == 7'h3F, "R6 reset glyph", segOut, 7'h3F);
      @(negedge clk);
    end
    pending.push_back(8'h00);
    waitMonitor();

    // sequence from the bring-up procedure
    writeByte(8'h01);
    idleBus(8'h00, 8'h01);
    writeByte(8'h00);

    // R1/R3/R4/R7: every byte, so every nibble at both positions
    for (int v = 0; v < 256; v++) writeByte(v[7:0]);

    // R2 with several bus patterns
    writeByte(8'hA5);
    idleBus(8'h5A, 8'hA5);
    idleBus(8'hFF, 8'hA5);
    idleBus(8'h00, 8'hA5);

    // R8: glyph follows a capture in the cycle after the edge
    @(negedge clk);
    dataIn = 8'h3C; writeEn = 1'b1;
    @(negedge clk);
    writeEn = 1'b0;
    check(segOut == (digitSel ? refGlyph(4'hC) : refGlyph(4'h3)), "R8 same-cycle glyph",
          segOut, digitSel ? refGlyph(4'hC) : refGlyph(4'h3));

    // R6: mid-run reset clears the stored byte and the select
    writeByte(8'h7E);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(digitSel == 1'b0, "R6 select after reset", digitSel, 0);
    check(segOut == 7'h3F, "R6 glyph after reset", segOut, 7'h3F);
    pending.push_back(8'h00);
    waitMonitor();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule